// File: doc/BRIEF.md
# Ping-pong frame capture controller

This block sequences the capture of whole video frames into memory. An upstream stage delivers pixel words with a start-of-frame marker on the first word and an end-of-frame marker on the last. The controller turns each accepted word into a memory-write request with a held address and data and a valid/ready handshake. Successive frames go to two base addresses in turn, so software can move the idle buffer while the other one is being filled.

Software works through two small register windows. The control window holds a capture enable, the two base addresses, a per-frame byte budget, a self-clearing soft reset, a sticky error code and a constant identification word. The interrupt window holds a mask and a pending-event register whose bits are cleared by writing ones. There is a completion bit for each buffer and one bit for errors. The interrupt line is high when any pending bit is also unmasked.

Top module: `pp_frame_capture`

## Requirements
- R1: The control word at offset 0x34 always reads 0xC0FB0001. After reset the enable (0x00), error status (0x1C) and interrupt status (interrupt window 0x0C) read 0, the interrupt line is low and no memory write is requested.
- R2: With enable bit 0 at offset 0x00 set, the first frame after enable goes to the base held at 0x0C and the next to the base at 0x10, and frames keep alternating. Word k of a frame is written to base + 4k.
- R3: Finishing a frame into the 0x0C buffer sets interrupt status bit 0. Finishing one into the 0x10 buffer sets bit 1.
- R4: The byte budget at 0x14 limits each frame. A word is written only if its last byte lies within the budget. Later words of that frame are dropped, and at end of frame status bit 3 and error status bit 0 are set.
- R5: A base address is captured when the frame that uses it starts. Rewriting either base register during a frame changes only frames that start later.
- R6: Clearing enable lets the frame in progress finish normally, including its completion bit. Frames that start while enable is low write nothing and set no bit. The next frame after enable is set again goes to the 0x0C buffer.
- R7: A start marker that arrives while a frame is open abandons that frame without a completion bit. It sets status bit 3 and error status bit 1, and the new frame goes to the same buffer.
- R8: Interrupt status (0x0C) and error status (0x1C) clear only the bits written as 1. Writing 0 has no effect, and an event arriving in the same cycle as a clear wins.
- R9: The interrupt line is the OR of the status bits ANDed with the mask at interrupt offset 0x08.
- R10: Writing 1 to bit 0 at 0x18 closes any open frame, clears interrupt status and error status, and returns the alternation to the 0x0C buffer. It keeps enable, base, budget and mask, and the register reads 0.
- R11: While a write request waits on memory ready, its address and data stay constant and no pixel word is accepted, so no word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Control window write strobe |
| cfg_addr | input | CFG_AW | Control window byte offset |
| cfg_wdata | input | 32 | Control window write data |
| cfg_rdata | output | 32 | Control window read data for cfg_addr |
| irq_we | input | 1 | Interrupt window write strobe |
| irq_addr | input | IRQ_AW | Interrupt window byte offset |
| irq_wdata | input | 4 | Interrupt window write data |
| irq_rdata | output | 32 | Interrupt window read data for irq_addr |
| irq | output | 1 | Interrupt request |
| pix_valid | input | 1 | Pixel word valid |
| pix_ready | output | 1 | Pixel word accepted when high with pix_valid |
| pix_data | input | DATA_W | Pixel word |
| pix_sof | input | 1 | Word is the first of a frame |
| pix_eof | input | 1 | Word is the last of a frame |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | ADDR_W | Byte address of the write |
| mem_data | output | DATA_W | Write data |

## Verification
Some relations are checked on every cycle: a completion or error event must show up in the pending bits on the next cycle, a soft reset must leave both status registers empty, the interrupt line must never rise with nothing pending, and a stalled write request must hold still. Other behaviour can only be shown by the bench's scenarios, because it depends on whole frames and on memory contents. This covers the alternation order, base addresses captured at frame start, truncation at the byte budget, the return to the first buffer after disable or soft reset, and the same-buffer restart after a missing end marker.

// File: rtl/pfc_pkg.sv
`timescale 1ns/1ps
package pfc_pkg;
  // control window offsets
  localparam int OFF_ENABLE = 'h00;
  localparam int OFF_BUFA   = 'h0C;
  localparam int OFF_BUFB   = 'h10;
  localparam int OFF_SIZE   = 'h14;
  localparam int OFF_SRST   = 'h18;
  localparam int OFF_ERR    = 'h1C;
  localparam int OFF_VER    = 'h34;
  // interrupt window offsets
  localparam int IOFF_MASK  = 'h8;
  localparam int IOFF_STAT  = 'hC;

  localparam logic [31:0] ID_WORD = 32'hC0FB_0001;

  localparam int NIRQ    = 4;
  localparam int IRQ_A   = 0;
  localparam int IRQ_B   = 1;
  localparam int IRQ_ERR = 3;

  localparam int ERR_W     = 2;
  localparam int ERR_OVF   = 0;
  localparam int ERR_TRUNC = 1;

  typedef struct packed {
    logic done_a;
    logic done_b;
    logic ovf;
    logic trunc;
  } pfc_evt_t;
endpackage

// File: rtl/pfc_regs.sv
`timescale 1ns/1ps
module pfc_regs
  import pfc_pkg::*;
#(
  parameter int AW = 6,
  parameter int RW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [RW-1:0]    wdata,
  output logic [RW-1:0]    rdata,
  input  logic [ERR_W-1:0] err_set,
  output logic             enable,
  output logic [RW-1:0]    buf_a,
  output logic [RW-1:0]    buf_b,
  output logic [RW-1:0]    size,
  output logic             sreset
);
  logic             en_q, en_n;
  logic [RW-1:0]    a_q, a_n, b_q, b_n, sz_q, sz_n;
  logic [ERR_W-1:0] err_q, err_n;

  assign sreset = we && (addr == AW'(OFF_SRST)) && wdata[0];

  always_comb begin
    en_n  = en_q;
    a_n   = a_q;
    b_n   = b_q;
    sz_n  = sz_q;
    err_n = err_q;
    if (we) begin
      case (addr)
        AW'(OFF_ENABLE): en_n  = wdata[0];
        AW'(OFF_BUFA):   a_n   = wdata;
        AW'(OFF_BUFB):   b_n   = wdata;
        AW'(OFF_SIZE):   sz_n  = wdata;
        AW'(OFF_ERR):    err_n = err_q & ~wdata[ERR_W-1:0];
        default: ;
      endcase
    end
    err_n = err_n | err_set;
    if (sreset) err_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      a_q   <= '0;
      b_q   <= '0;
      sz_q  <= '0;
      err_q <= '0;
    end else begin
      en_q  <= en_n;
      a_q   <= a_n;
      b_q   <= b_n;
      sz_q  <= sz_n;
      err_q <= err_n;
    end
  end

  always_comb begin
    case (addr)
      AW'(OFF_ENABLE): rdata = RW'(en_q);
      AW'(OFF_BUFA):   rdata = a_q;
      AW'(OFF_BUFB):   rdata = b_q;
      AW'(OFF_SIZE):   rdata = sz_q;
      AW'(OFF_ERR):    rdata = RW'(err_q);
      AW'(OFF_VER):    rdata = RW'(ID_WORD);
      default:         rdata = '0;
    endcase
  end

  assign enable = en_q;
  assign buf_a  = a_q;
  assign buf_b  = b_q;
  assign size   = sz_q;
endmodule

// File: rtl/pfc_irq.sv
`timescale 1ns/1ps
module pfc_irq
  import pfc_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = NIRQ,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] wdata,
  output logic [RW-1:0] rdata,
  input  logic [NB-1:0] set_vec,
  input  logic          sreset,
  output logic          irq
);
  logic [NB-1:0] stat_q, stat_n, mask_q, mask_n;
  logic          clr_hit, mask_hit;

  assign clr_hit  = we && (addr == AW'(IOFF_STAT));
  assign mask_hit = we && (addr == AW'(IOFF_MASK));

  for (genvar g = 0; g < NB; g++) begin : g_bit
    assign stat_n[g] = sreset ? 1'b0
                     : (set_vec[g] | (stat_q[g] & ~(clr_hit & wdata[g])));
  end

  assign mask_n = mask_hit ? wdata : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_n;
      mask_q <= mask_n;
    end
  end

  always_comb begin
    case (addr)
      AW'(IOFF_MASK): rdata = RW'(mask_q);
      AW'(IOFF_STAT): rdata = RW'(stat_q);
      default:        rdata = '0;
    endcase
  end

  assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/pfc_engine.sv
`timescale 1ns/1ps
module pfc_engine
  import pfc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sreset,
  input  logic [ADDR_W-1:0] buf_a,
  input  logic [ADDR_W-1:0] buf_b,
  input  logic [CNT_W-1:0]  size,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              pix_sof,
  input  logic              pix_eof,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output pfc_evt_t          evt
);
  localparam int BPW = DATA_W / 8;
  localparam logic [CNT_W:0] STEP = (CNT_W + 1)'(BPW);

  logic              act_q, act_n, sel_q, sel_n, ovf_q, ovf_n;
  logic [ADDR_W-1:0] base_q, base_n, ma_q, ma_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] md_q, md_n;
  logic              mv_q, mv_n, accept, load;

  assign pix_ready = ~mv_q | mem_ready;
  assign accept    = pix_valid & pix_ready;

  always_comb begin
    act_n  = act_q;
    sel_n  = sel_q;
    ovf_n  = ovf_q;
    base_n = base_q;
    cnt_n  = cnt_q;
    mv_n   = mv_q & ~mem_ready;
    ma_n   = ma_q;
    md_n   = md_q;
    load   = 1'b0;
    evt    = '0;
    if (accept) begin
      if (pix_sof) begin
        evt.trunc = act_q;
        act_n     = enable;
        base_n    = sel_q ? buf_b : buf_a;
        cnt_n     = '0;
        ovf_n     = 1'b0;
      end
      if (act_n) begin
        if (({1'b0, cnt_n} + STEP) <= {1'b0, size}) begin
          load  = 1'b1;
          mv_n  = 1'b1;
          ma_n  = base_n + ADDR_W'(cnt_n);
          md_n  = pix_data;
          cnt_n = cnt_n + CNT_W'(BPW);
        end else begin
          ovf_n = 1'b1;
        end
        if (pix_eof) begin
          evt.done_a = ~sel_q;
          evt.done_b = sel_q;
          evt.ovf    = ovf_n;
          sel_n      = ~sel_q;
          act_n      = 1'b0;
        end
      end
    end
    if (!enable && !act_n) sel_n = 1'b0;
    if (sreset) begin
      act_n = 1'b0;
      sel_n = 1'b0;
      ovf_n = 1'b0;
      mv_n  = mv_q & ~mem_ready;
      load  = 1'b0;
      evt   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_n_reset: begin
        act_q  <= 1'b0;
        sel_q  <= 1'b0;
        ovf_q  <= 1'b0;
        mv_q   <= 1'b0;
        base_q <= '0;
        cnt_q  <= '0;
        ma_q   <= '0;
        md_q   <= '0;
      end
    end else begin
      act_q  <= act_n;
      sel_q  <= sel_n;
      ovf_q  <= ovf_n;
      mv_q   <= mv_n;
      base_q <= base_n;
      cnt_q  <= cnt_n;
      if (load) begin
        ma_q <= ma_n;
        md_q <= md_n;
      end
    end
  end

  assign mem_valid = mv_q;
  assign mem_addr  = ma_q;
  assign mem_data  = md_q;
endmodule

// File: rtl/pp_frame_capture.sv
`timescale 1ns/1ps
module pp_frame_capture
  import pfc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CFG_AW = 6,
  parameter int IRQ_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              irq_we,
  input  logic [IRQ_AW-1:0] irq_addr,
  input  logic [NIRQ-1:0]   irq_wdata,
  output logic [31:0]       irq_rdata,
  output logic              irq,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              pix_sof,
  input  logic              pix_eof,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);
  localparam int RW = 32;

  logic             rst_meta, rst_sync_n;
  logic             enable, soft_rst;
  logic [RW-1:0]    buf_a, buf_b, size;
  pfc_evt_t         evt;
  logic [NIRQ-1:0]  set_vec;
  logic [ERR_W-1:0] err_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    set_vec          = '0;
    set_vec[IRQ_A]   = evt.done_a;
    set_vec[IRQ_B]   = evt.done_b;
    set_vec[IRQ_ERR] = evt.ovf | evt.trunc;
    err_set            = '0;
    err_set[ERR_OVF]   = evt.ovf;
    err_set[ERR_TRUNC] = evt.trunc;
  end

  pfc_regs #(.AW(CFG_AW), .RW(RW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .err_set(err_set),
    .enable(enable), .buf_a(buf_a), .buf_b(buf_b), .size(size),
    .sreset(soft_rst)
  );

  pfc_irq #(.AW(IRQ_AW), .NB(NIRQ), .RW(RW)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .we(irq_we), .addr(irq_addr),
    .wdata(irq_wdata), .rdata(irq_rdata), .set_vec(set_vec),
    .sreset(soft_rst), .irq(irq)
  );

  pfc_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(RW)) u_engine (
    .clk(clk), .rst_n(rst_sync_n), .enable(enable), .sreset(soft_rst),
    .buf_a(buf_a[ADDR_W-1:0]), .buf_b(buf_b[ADDR_W-1:0]), .size(size),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .pix_sof(pix_sof), .pix_eof(pix_eof), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .evt(evt)
  );
endmodule

// File: rtl/pfc_checker.sv
`timescale 1ns/1ps
module pfc_checker
  import pfc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              done_a,
  input logic              done_b,
  input logic              ovf,
  input logic              trunc,
  input logic              sreset,
  input logic [NIRQ-1:0]   status,
  input logic [ERR_W-1:0]  errstat,
  input logic              irq
);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  assert_done_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_a |=> status[IRQ_A]);

  assert_done_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_b |=> status[IRQ_B]);

  assert_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (status[IRQ_ERR] && errstat[ERR_OVF]));

  assert_trunc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trunc |=> (status[IRQ_ERR] && errstat[ERR_TRUNC]));

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> (status == '0 && errstat == '0));

  assert_irq_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));
endmodule

bind pp_frame_capture pfc_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pfc_checker (
  .clk(clk), .rst_n(rst_sync_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .done_a(evt.done_a),
  .done_b(evt.done_b), .ovf(evt.ovf), .trunc(evt.trunc), .sreset(soft_rst),
  .status(u_irq.stat_q), .errstat(u_regs.err_q), .irq(irq)
);

// File: tb/pp_frame_capture_bench.sv
`timescale 1ns/1ps
module pp_frame_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        irq_we;
  logic [3:0]  irq_addr;
  logic [3:0]  irq_wdata;
  logic [31:0] irq_rdata;
  logic        irq;
  logic        pix_valid, pix_ready, pix_sof, pix_eof;
  logic [31:0] pix_data;
  logic        mem_valid, mem_ready;
  logic [31:0] mem_addr, mem_data;

  localparam logic [31:0] SENT = 32'hDEAD_BEEF;
  localparam logic [31:0] BASE_A = 32'h100;
  localparam logic [31:0] BASE_B = 32'h200;
  // vector table: words sent, byte budget, expected status, expected error code
  localparam int NV = 6;
  localparam int VN  [NV] = '{4, 3, 8, 1, 4, 5};
  localparam int VS  [NV] = '{64, 64, 16, 64, 16, 18};
  localparam int VST [NV] = '{1, 2, 9, 2, 1, 10};
  localparam int VE  [NV] = '{0, 0, 1, 0, 0, 1};

  logic [31:0] mem [1024];
  int wr_count = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pp_frame_capture u_pp_frame_capture (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_we(irq_we),
    .irq_addr(irq_addr), .irq_wdata(irq_wdata), .irq_rdata(irq_rdata),
    .irq(irq), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .pix_sof(pix_sof), .pix_eof(pix_eof),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data)
  );

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      mem[mem_addr[11:2]] <= mem_data;
      wr_count <= wr_count + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 1024; i++) mem[i] = SENT;
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic irq_write(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); irq_we = 1'b1; irq_addr = a; irq_wdata = d;
    @(negedge clk); irq_we = 1'b0;
  endtask

  task automatic irq_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); irq_addr = a; #1 d = irq_rdata;
  endtask

  task automatic send_beats(input int n, input logic [31:0] tag, input bit sof_first, input bit eof_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_sof   = sof_first && (i == 0);
      pix_eof   = eof_last && (i == n - 1);
      pix_data  = tag + 32'(i);
      #1;
      while (!pix_ready) begin
        @(negedge clk); #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eof = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_all();
    irq_write(4'hC, 4'hF);
    cfg_write(6'h1C, 32'h3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] base;
    int nw, w0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    irq_we = 1'b0; irq_addr = '0; irq_wdata = '0;
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eof = 1'b0; pix_data = '0;
    mem_ready = 1'b1;
    fill_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state and identification word
    cfg_read(6'h34, rd); check("R1 id word", rd, 32'hC0FB_0001);
    cfg_read(6'h00, rd); check("R1 enable after reset", rd, 32'h0);
    cfg_read(6'h1C, rd); check("R1 error status after reset", rd, 32'h0);
    irq_read(4'hC, rd);  check("R1 status after reset", rd, 32'h0);
    check("R1 irq after reset", 32'(irq), 32'h0);
    check("R1 no write after reset", 32'(mem_valid), 32'h0);

    cfg_write(6'h0C, BASE_A);
    cfg_write(6'h10, BASE_B);
    irq_write(4'h8, 4'hF);
    cfg_write(6'h00, 32'h1);

    // table walk: R2 alternation, R3 completion bits, R4 budget
    for (int v = 0; v < NV; v++) begin
      fill_mem();
      cfg_write(6'h14, 32'(VS[v]));
      send_beats(VN[v], 32'hA000_0000 + 32'(v << 8), 1'b1, 1'b1);
      settle();
      base = (v % 2 == 1) ? BASE_B : BASE_A;
      nw = (VN[v] < VS[v] / 4) ? VN[v] : VS[v] / 4;
      for (int k = 0; k < nw; k++)
        check("R2 frame word", mem[(base >> 2) + 32'(k)], 32'hA000_0000 + 32'(v << 8) + 32'(k));
      check("R4 word past budget untouched", mem[(base >> 2) + 32'(nw)], SENT);
      irq_read(4'hC, rd);  check("R3 status bits", rd, 32'(VST[v]));
      cfg_read(6'h1C, rd); check("R4 error status", rd, 32'(VE[v]));
      check("R9 irq with mask set", 32'(irq), 32'h1);
      clear_all();
      irq_read(4'hC, rd);  check("R8 status cleared", rd, 32'h0);
    end
    cfg_write(6'h14, 32'd64);

    // R8: partial clear (frame into A)
    send_beats(2, 32'hB000_0000, 1'b1, 1'b1); settle();
    irq_write(4'hC, 4'h2);
    irq_read(4'hC, rd); check("R8 clear of unset bit", rd, 32'h1);
    irq_write(4'hC, 4'h0);
    irq_read(4'hC, rd); check("R8 write zero", rd, 32'h1);
    irq_write(4'hC, 4'h1);
    irq_read(4'hC, rd); check("R8 write one clears", rd, 32'h0);

    // R9: mask (frame into B)
    irq_write(4'h8, 4'h0);
    send_beats(2, 32'hB100_0000, 1'b1, 1'b1); settle();
    check("R9 masked irq low", 32'(irq), 32'h0);
    irq_write(4'h8, 4'h2);
    check("R9 unmasked irq high", 32'(irq), 32'h1);
    irq_write(4'h8, 4'h1);
    check("R9 other bit masked", 32'(irq), 32'h0);
    irq_write(4'h8, 4'hF);
    clear_all();

    // R5: base rewrite mid-frame (frame into A)
    fill_mem();
    send_beats(2, 32'hC000_0000, 1'b1, 1'b0);
    cfg_write(6'h0C, 32'h300);
    cfg_write(6'h10, 32'h280);
    send_beats(2, 32'hC000_0002, 1'b0, 1'b1); settle();
    check("R5 current frame keeps base", mem[(BASE_A >> 2) + 3], 32'hC000_0003);
    check("R5 new base unused mid-frame", mem[32'h300 >> 2], SENT);
    send_beats(2, 32'hC100_0000, 1'b1, 1'b1); settle();
    check("R5 later frame uses new base", mem[32'h280 >> 2], 32'hC100_0000);
    cfg_write(6'h0C, BASE_A);
    cfg_write(6'h10, BASE_B);
    clear_all();

    // R6: disable mid-frame (frame into A)
    fill_mem();
    send_beats(2, 32'hD000_0000, 1'b1, 1'b0);
    cfg_write(6'h00, 32'h0);
    send_beats(2, 32'hD000_0002, 1'b0, 1'b1); settle();
    check("R6 open frame finishes", mem[(BASE_A >> 2) + 3], 32'hD000_0003);
    irq_read(4'hC, rd); check("R6 open frame completion", rd, 32'h1);
    clear_all();
    w0 = wr_count;
    send_beats(3, 32'hD100_0000, 1'b1, 1'b1); settle();
    check("R6 disabled frame writes nothing", 32'(wr_count - w0), 32'h0);
    irq_read(4'hC, rd); check("R6 disabled frame no status", rd, 32'h0);
    cfg_write(6'h00, 32'h1);
    send_beats(2, 32'hD200_0000, 1'b1, 1'b1); settle();
    check("R6 re-enable starts at A", mem[BASE_A >> 2], 32'hD200_0000);
    irq_read(4'hC, rd); check("R6 re-enable completion A", rd, 32'h1);
    clear_all();

    // R7: missing end marker (frame into B)
    fill_mem();
    send_beats(2, 32'hE000_0000, 1'b1, 1'b0);
    send_beats(2, 32'hE100_0000, 1'b1, 1'b1); settle();
    irq_read(4'hC, rd);  check("R7 status after restart", rd, 32'hA);
    cfg_read(6'h1C, rd); check("R7 error status", rd, 32'h2);
    check("R7 restart into same buffer", mem[BASE_B >> 2], 32'hE100_0000);
    clear_all();

    // R10: soft reset (overflow frame into A)
    cfg_write(6'h14, 32'd4);
    send_beats(2, 32'hF000_0000, 1'b1, 1'b1); settle();
    irq_read(4'hC, rd); check("R4 overflow status before reset", rd, 32'h9);
    cfg_write(6'h18, 32'h1);
    irq_read(4'hC, rd);  check("R10 status cleared", rd, 32'h0);
    cfg_read(6'h1C, rd); check("R10 error cleared", rd, 32'h0);
    cfg_read(6'h18, rd); check("R10 reset reads zero", rd, 32'h0);
    cfg_read(6'h0C, rd); check("R10 base kept", rd, BASE_A);
    cfg_write(6'h14, 32'd64);
    fill_mem();
    send_beats(1, 32'hF100_0000, 1'b1, 1'b1); settle();
    check("R10 alternation back to A", mem[BASE_A >> 2], 32'hF100_0000);
    irq_read(4'hC, rd); check("R10 completion A", rd, 32'h1);
    clear_all();

    // R11: backpressure (frame into B)
    fill_mem();
    @(negedge clk); mem_ready = 1'b0;
    send_beats(1, 32'h7000_0000, 1'b1, 1'b0);
    #1;
    check("R11 request pending", 32'(mem_valid), 32'h1);
    check("R11 no accept while stalled", 32'(pix_ready), 32'h0);
    repeat (3) @(negedge clk);
    check("R11 address held", mem_addr, BASE_B);
    check("R11 data held", mem_data, 32'h7000_0000);
    mem_ready = 1'b1;
    send_beats(4, 32'h7000_0001, 1'b0, 1'b1); settle();
    for (int k = 0; k < 5; k++)
      check("R11 no word lost", mem[(BASE_B >> 2) + 32'(k)], 32'h7000_0000 + 32'(k));

    finish_run();
  end
endmodule